// File: doc/BRIEF.md
# Ordered Power-Rail Sequencer Chain

This block drives six rail-enable outputs. It switches them on one after another in ascending order and off again in the reverse order. A single enable level selects the direction. A one-cycle step pulse sets the pace: each pulse moves the sequence by exactly one rail, so the spacing between rails depends only on how often steps arrive.

The chain is a row of one-bit cells. On a step, each cell copies either its lower neighbour or its upper neighbour, depending on the synchronized enable. Power-up and power-down therefore run through the same flops. If the command reverses partway through a sequence, the sequence turns around from the rail it had reached, and no extra control logic is needed. Two combinational flags report when every rail is on or every rail is off. A surrounding step generator can use these flags to stop once the chain has settled.

Top module: `rail_sequencer`

## Requirements
- R1: A synchronous active-high reset clears all rails to off, which makes `all_off` 1 and `all_on` 0.
- R2: `en_req` passes through a two-flop synchronizer. A level captured at clock edge n can first change the rails at edge n+2, and only if a step is present at that edge.
- R3: While the synchronized enable is high, each step turns on the lowest rail that is still off. Rail 1 (bit 0) goes first and rail 6 (bit 5) goes last. Extra steps with all rails on change nothing.
- R4: In a cycle without a step, no rail changes, whatever the enable does.
- R5: While the synchronized enable is low, each step turns off the highest rail that is still on. Rail 6 (bit 5) goes first and rail 1 goes last. Extra steps with all rails off change nothing.
- R6: If enable drops partway through power-up, the rails that are still off stay off. The rails that are on then power down from the top.
- R7: If enable rises partway through power-down, the rails that are still on stay on. Power-up resumes from the lowest rail that is off.
- R8: `all_on` is 1 exactly when all six rails are on. `all_off` is 1 exactly when all six are off. Both follow the rails in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_req | input | 1 | Asynchronous on/off command (1 = power up) |
| step_tick | input | 1 | One-cycle pulse that advances the sequence by one rail |
| rail_on | output | 6 | Rail enables, bit 0 = rail 1 |
| all_on | output | 1 | All rails on |
| all_off | output | 1 | All rails off |

## Verification
A change on `en_req` can first reach the rails at the second clock edge after the edge that captured it. The first rail moves only if a step arrives at that edge, and each later rail moves on a later step. The flags follow in the same cycle as the rails. The bench keeps a count of lit rails and a two-deep copy of the enable, and applies each step at the same clock edge as the design. It drives inputs at the falling edge and compares the rails and flags one time unit after every rising edge, so each result is sampled in the cycle it is due.

// File: rtl/rail_seq_pkg.sv
package rail_seq_pkg;

    // Direction in which the chain moves on a step
    typedef enum logic {
        SEQ_DOWN = 1'b0,
        SEQ_UP   = 1'b1
    } seq_dir_e;

    // Values seen by one cell from its two neighbours
    typedef struct packed {
        logic lower;
        logic upper;
    } nbr_t;

    // Neighbour-select: copy the lower cell going up, the upper cell going down
    function automatic logic pick_next(input seq_dir_e dir, input nbr_t nbr);
        return (dir == SEQ_UP) ? nbr.lower : nbr.upper;
    endfunction

endpackage

// File: rtl/enable_sync.sv
module enable_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] st;

    always_ff @(posedge clk) begin
        if (rst) st <= '0;
        else     st <= {st[STAGES-2:0], d_async};
    end

    assign q_sync = st[STAGES-1];

    assert_sync_in_R2: assert property (@(posedge clk) disable iff (rst)
        st[0] == $past(d_async));

    for (genvar k = 1; k < STAGES; k++) begin : g_chk
        assert_sync_stage_R2: assert property (@(posedge clk) disable iff (rst)
            st[k] == $past(st[k-1]));
    end
endmodule

// File: rtl/seq_cell.sv
module seq_cell
    import rail_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  seq_dir_e dir,
    input  nbr_t     nbr,
    output logic     q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= 1'b0;
        else if (tick) q <= pick_next(dir, nbr);
    end

    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(q));
endmodule

// File: rtl/rail_sequencer.sv
module rail_sequencer
    import rail_seq_pkg::*;
#(
    parameter int NUM_RAILS   = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en_req,
    input  logic                 step_tick,
    output logic [NUM_RAILS-1:0] rail_on,
    output logic                 all_on,
    output logic                 all_off
);
    localparam int LAST = NUM_RAILS - 1;

    logic     en_s;
    seq_dir_e dir;
    nbr_t     nbr [NUM_RAILS];

    enable_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (en_req),
        .q_sync  (en_s)
    );

    assign dir = seq_dir_e'(en_s);

    for (genvar i = 0; i < NUM_RAILS; i++) begin : g_cell
        // First cell: the lower neighbour is the enable itself (en | rail 2)
        if (i == 0) begin : g_lo_end
            assign nbr[i].lower = en_s;
        end else begin : g_lo_mid
            assign nbr[i].lower = rail_on[i-1];
        end
        // Last cell: the upper neighbour is tied low (en & rail 5)
        if (i == LAST) begin : g_hi_end
            assign nbr[i].upper = 1'b0;
        end else begin : g_hi_mid
            assign nbr[i].upper = rail_on[i+1];
        end

        seq_cell u_cell (
            .clk  (clk),
            .rst  (rst),
            .tick (step_tick),
            .dir  (dir),
            .nbr  (nbr[i]),
            .q    (rail_on[i])
        );

        if (i > 0) begin : g_up_chk
            assert_up_order_R3: assert property (@(posedge clk) disable iff (rst)
                $rose(rail_on[i]) |-> $past(rail_on[i-1]));
        end
        if (i < LAST) begin : g_dn_chk
            assert_down_order_R5: assert property (@(posedge clk) disable iff (rst)
                $fell(rail_on[i]) |-> !$past(rail_on[i+1]));
        end
    end

    assign all_on  = &rail_on;
    assign all_off = ~|rail_on;

    assert_one_step_R3: assert property (@(posedge clk) disable iff (rst)
        $countones(rail_on ^ $past(rail_on)) <= 1);

    assert_flags_excl_R8: assert property (@(posedge clk) disable iff (rst)
        !(all_on && all_off));

    assert_reset_clear_R1: assert property (@(posedge clk)
        $past(rst) |-> (rail_on == '0));
endmodule

// File: tb/rail_sequencer_test.sv
module rail_sequencer_test;
    localparam int CLK_PERIOD = 10;
    localparam int N = 6;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         en_req = 1'b0;
    logic         step_tick = 1'b0;
    logic [N-1:0] rail_on;
    logic         all_on, all_off;

    int n_tests = 0;
    int n_fail  = 0;

    // Bench model: number of lit rails plus a two-deep copy of the enable
    int   k  = 0;
    logic d1 = 1'b0;
    logic d2 = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rail_sequencer uut (
        .clk       (clk),
        .rst       (rst),
        .en_req    (en_req),
        .step_tick (step_tick),
        .rail_on   (rail_on),
        .all_on    (all_on),
        .all_off   (all_off)
    );

    function automatic logic [N-1:0] thermo(input int cnt);
        logic [N:0] w;
        w = (7'(1) << cnt) - 7'(1);
        return w[N-1:0];
    endfunction

    task automatic check(input string tag);
        logic [N-1:0] exp;
        exp = thermo(k);
        n_tests++;
        if (rail_on !== exp) begin
            n_fail++;
            $display("FAIL %s: rail_on=%b expected %b", tag, rail_on, exp);
        end
        n_tests++;
        if (all_on !== (k == N) || all_off !== (k == 0)) begin
            n_fail++;
            $display("FAIL R8 (%s): all_on=%b all_off=%b expected %b %b",
                     tag, all_on, all_off, (k == N), (k == 0));
        end
    endtask

    task automatic step(input logic e, input logic t, input string tag);
        @(negedge clk);
        en_req = e;
        step_tick = t;
        @(posedge clk);
        if (t) begin
            if (d2) k = (k < N) ? k + 1 : k;
            else    k = (k > 0) ? k - 1 : 0;
        end
        d2 = d1;
        d1 = e;
        #1;
        check(tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        en_req = 1'b0;
        step_tick = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        k = 0; d1 = 1'b0; d2 = 1'b0;
        check("R1");
        @(negedge clk);
        rst = 1'b0;
        step_tick = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] lf;
        do_reset();

        // R2: the first two edges after raising the enable must not move any rail
        step(1'b1, 1'b1, "R2");
        step(1'b1, 1'b1, "R2");
        // R3: ascending power-up, then saturation
        for (int i = 0; i < N + 2; i++) step(1'b1, 1'b1, "R3");
        // R4: no step, enable toggled, nothing moves
        for (int i = 0; i < 5; i++) step(1'(i % 2), 1'b0, "R4");
        step(1'b1, 1'b0, "R4");
        step(1'b1, 1'b0, "R4");
        // R5: descending power-down, then saturation
        for (int i = 0; i < N + 4; i++) step(1'b0, 1'b1, "R5");

        // R6: drop the enable partway through power-up
        for (int i = 0; i < 4; i++) step(1'b1, 1'b1, "R6");
        for (int i = 0; i < 6; i++) step(1'b0, 1'b1, "R6");

        // R7: raise the enable partway through power-down
        for (int i = 0; i < N + 3; i++) step(1'b1, 1'b1, "R7");
        for (int i = 0; i < 4; i++) step(1'b0, 1'b1, "R7");
        for (int i = 0; i < N + 3; i++) step(1'b1, 1'b1, "R7");

        // R1: reset in the middle of a sequence
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1, "R5");
        do_reset();

        // Sweep over pseudo-random enable/step patterns (R3, R5, R6, R7)
        lf = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            step(lf[3] | (lf[7] & lf[1]), lf[0] | lf[5], "sweep R3 R5");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule